// File: doc/BRIEF.md
# Selectable-Polynomial Byte CRC Engine

This block keeps a running cyclic redundancy checksum over a stream of bytes. Each cycle in which the byte strobe is high, one whole byte is folded into the checksum register. Any number of bytes may be accumulated. The generator polynomial is picked at run time from three choices: one 8-bit and two 16-bit. A separate control picks the bit order within each byte, so the checksum matches the order in which a serial link sends bits.

The checksum always starts from zero. A clear input returns the register to zero. Any change of the polynomial select also returns it to zero, so a stream never mixes two polynomials. The result is always visible on a 16-bit output. When the 8-bit polynomial is active, the result sits in the low byte.

Top module: `crc_multi_engine`

## Requirements
- R1: While the asynchronous active-low reset is asserted, and on the first clock after its release with no byte strobe, the result output reads 16'h0000.
- R2: Select code 0 uses the 8-bit generator x^8+x^2+x+1 (hex 07 in top-bit-first form). With it, result bits 15..8 always read zero. From zero, the ASCII string "123456789" in top-bit-first order gives 8'hF4.
- R3: Select code 1 uses the 16-bit generator x^16+x^15+x^2+1 (hex 8005). From zero, "123456789" gives 16'hFEE8 in top-bit-first order and 16'hBB3D in low-bit-first order.
- R4: Select code 2 uses the 16-bit generator x^16+x^12+x^5+1 (hex 1021). From zero, "123456789" gives 16'h31C3 in top-bit-first order and 16'h2189 in low-bit-first order.
- R5: Select code 3 is reserved and behaves exactly like code 0.
- R6: With the order input at 0, the register shifts toward its top bit. It takes byte bit 7 first, with feedback from the top bit of the active width.
- R7: With the order input at 1, the register shifts toward bit 0 using the bit-reversed generator. It takes byte bit 0 first, with feedback from bit 0.
- R8: A strobed byte is fully absorbed at one clock edge, and the updated result is visible right after that edge. Consecutive strobed bytes accumulate.
- R9: With strobe low, clear low and the select unchanged from the previous cycle, the result holds its value.
- R10: A high clear input makes the result zero after the edge and discards any byte strobed in that cycle.
- R11: A select value that differs from the one of the previous clocked cycle makes the result zero after the edge and discards any byte strobed in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_i | input | 8 | Data byte to absorb |
| byte_vld_i | input | 1 | Byte strobe, one byte per high cycle |
| poly_sel_i | input | 2 | Generator select: 0 8-bit, 1 hex 8005, 2 hex 1021, 3 same as 0 |
| lsb_first_i | input | 1 | 1: low bit of each byte first; 0: top bit first |
| clear_i | input | 1 | Return the checksum to zero |
| crc_o | output | 16 | Current checksum |

## Verification
The bound assertions check four things on every cycle: zero after a clear, zero after a select change, holding while idle, and the empty upper byte in 8-bit mode. Whether the arithmetic is right for each generator and bit order can only be shown by the bench. It checks standard check strings with known residues and long random streams against a bit-serial model in the bench. The reserved select code, and the discarding of a byte that arrives together with a clear or a select change, are also shown only by those scenarios.

// File: rtl/crc_pkg.sv
package crc_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned CRC_W    = 16;
  localparam int unsigned NUM_POLY = 3;
  localparam int unsigned SEL_W    = 2;
  localparam int unsigned NUM_LANE = NUM_POLY * 2;

  typedef logic [CRC_W-1:0]  crc_t;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [SEL_W-1:0]  sel_t;

  // width of the generator for each lane index
  function automatic int unsigned poly_width(int unsigned idx);
    return (idx == 0) ? 8 : 16;
  endfunction

  // generator in top-bit-first form, leading term implied
  function automatic crc_t poly_value(int unsigned idx);
    case (idx)
      0:       return 16'h0007;
      1:       return 16'h8005;
      default: return 16'h1021;
    endcase
  endfunction

  // mirror the low w bits of v
  function automatic crc_t mirror(crc_t v, int unsigned w);
    crc_t r;
    r = '0;
    for (int unsigned i = 0; i < w; i++) r[w-1-i] = v[i];
    return r;
  endfunction

  // reserved select code folds onto the 8-bit generator
  function automatic sel_t lane_of(sel_t sel);
    return (sel == sel_t'(3)) ? sel_t'(0) : sel;
  endfunction
endpackage

// File: rtl/crc_byte_step.sv
module crc_byte_step
  import crc_pkg::*;
#(
  parameter int unsigned WIDTH     = 16,
  parameter crc_t        POLY      = 16'h1021,
  parameter bit          LSB_FIRST = 1'b0
) (
  input  byte_t            data_i,
  input  logic [WIDTH-1:0] crc_i,
  output logic [WIDTH-1:0] crc_o
);
  localparam logic [WIDTH-1:0] TAPS = POLY[WIDTH-1:0];

  logic [WIDTH-1:0] stage [BYTE_W+1];
  assign stage[0] = crc_i;

  for (genvar k = 0; k < BYTE_W; k++) begin : g_bit
    logic din, fb;
    if (LSB_FIRST) begin : g_right
      assign din = data_i[k];
      assign fb  = stage[k][0] ^ din;
      assign stage[k+1] = (stage[k] >> 1) ^ ({WIDTH{fb}} & TAPS);
    end else begin : g_left
      assign din = data_i[BYTE_W-1-k];
      assign fb  = stage[k][WIDTH-1] ^ din;
      assign stage[k+1] = (stage[k] << 1) ^ ({WIDTH{fb}} & TAPS);
    end
  end

  assign crc_o = stage[BYTE_W];
endmodule

// File: rtl/crc_poly_bank.sv
module crc_poly_bank
  import crc_pkg::*;
(
  input  crc_t  crc_i,
  input  byte_t data_i,
  input  sel_t  lane_i,
  input  logic  lsb_i,
  output crc_t  next_o
);
  crc_t cand [NUM_LANE];

  for (genvar p = 0; p < NUM_POLY; p++) begin : g_poly
    localparam int unsigned W = poly_width(p);
    for (genvar o = 0; o < 2; o++) begin : g_ord
      localparam crc_t TAPS = (o == 1) ? mirror(poly_value(p), W) : poly_value(p);
      logic [W-1:0] step_out;
      crc_byte_step #(
        .WIDTH    (W),
        .POLY     (TAPS),
        .LSB_FIRST(o == 1)
      ) u_step (
        .data_i(data_i),
        .crc_i (crc_i[W-1:0]),
        .crc_o (step_out)
      );
      assign cand[p*2+o] = crc_t'(step_out);
    end
  end

  always_comb begin
    next_o = '0;
    for (int unsigned i = 0; i < NUM_LANE; i++) begin
      if ((32'(lane_i) * 2 + 32'(lsb_i)) == i) next_o = cand[i];
    end
  end
endmodule

// File: rtl/crc_seq_ctrl.sv
module crc_seq_ctrl
  import crc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  sel_t sel_i,
  input  logic clear_i,
  input  logic valid_i,
  output sel_t lane_o,
  output logic flush_o,
  output logic load_o
);
  sel_t sel_q, sel_d;

  assign sel_d   = sel_i;
  assign flush_o = clear_i | (sel_i != sel_q);
  assign load_o  = valid_i & ~flush_o;
  assign lane_o  = lane_of(sel_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= sel_d;
  end
endmodule

// File: rtl/crc_multi_engine.sv
module crc_multi_engine
  import crc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  byte_i,
  input  logic        byte_vld_i,
  input  logic [1:0]  poly_sel_i,
  input  logic        lsb_first_i,
  input  logic        clear_i,
  output logic [15:0] crc_o
);
  crc_t crc_q, crc_d, bank_next;
  sel_t lane;
  logic flush, load, crc_en;

  crc_seq_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel_i  (poly_sel_i),
    .clear_i(clear_i),
    .valid_i(byte_vld_i),
    .lane_o (lane),
    .flush_o(flush),
    .load_o (load)
  );

  crc_poly_bank u_bank (
    .crc_i (crc_q),
    .data_i(byte_i),
    .lane_i(lane),
    .lsb_i (lsb_first_i),
    .next_o(bank_next)
  );

  assign crc_en = flush | load;

  always_comb begin
    if (flush) crc_d = '0;
    else       crc_d = bank_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= '0;
    else if (crc_en) crc_q <= crc_d;
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/crc_multi_engine_chk.sv
module crc_multi_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  byte_i,
  input logic        byte_vld_i,
  input logic [1:0]  poly_sel_i,
  input logic        lsb_first_i,
  input logic        clear_i,
  input logic [15:0] crc_o
);
  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (crc_o == 16'h0000)); // R10

  AST_SEL_CHANGE_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && (poly_sel_i != $past(poly_sel_i))) |=> (crc_o == 16'h0000)); // R11

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !byte_vld_i && !clear_i && $stable(poly_sel_i)) |=> $stable(crc_o)); // R9

  AST_NARROW_UPPER_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (poly_sel_i == 2'd0 || poly_sel_i == 2'd3) |=> (crc_o[15:8] == 8'h00)); // R2

  AST_RESET_RELEASE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rst_n) && !byte_vld_i) |-> (crc_o == 16'h0000)); // R1
endmodule

bind crc_multi_engine crc_multi_engine_chk u_chk (.*);

// File: tb/test_crc_multi_engine.sv
module test_crc_multi_engine;
  logic        clk;
  logic        rst_n;
  logic [7:0]  byte_i;
  logic        byte_vld_i;
  logic [1:0]  poly_sel_i;
  logic        lsb_first_i;
  logic        clear_i;
  logic [15:0] crc_o;

  int unsigned n_run  = 0;
  int unsigned n_fail = 0;
  bit          done   = 0;

  logic [15:0] exp_crc;
  logic [1:0]  exp_sel;

  crc_multi_engine i_crc_multi_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_i     (byte_i),
    .byte_vld_i (byte_vld_i),
    .poly_sel_i (poly_sel_i),
    .lsb_first_i(lsb_first_i),
    .clear_i    (clear_i),
    .crc_o      (crc_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // bit-serial reference taken from the requirement text
  function automatic logic [15:0] ref_step(logic [15:0] c, logic [7:0] d,
                                           logic [1:0] sel, logic lsb);
    int unsigned w;
    logic [15:0] g, m;
    case (sel)
      2'd1:    begin w = 16; g = 16'h8005; end
      2'd2:    begin w = 16; g = 16'h1021; end
      default: begin w = 8;  g = 16'h0007; end
    endcase
    m = (w == 8) ? 16'h00FF : 16'hFFFF;
    if (lsb) begin
      logic [15:0] rg;
      rg = '0;
      for (int i = 0; i < w; i++) rg[w-1-i] = g[i];
      for (int i = 0; i < 8; i++) begin
        logic fb;
        fb = c[0] ^ d[i];
        c  = (c >> 1) ^ (fb ? rg : 16'h0);
      end
    end else begin
      for (int i = 7; i >= 0; i--) begin
        logic fb;
        fb = c[w-1] ^ d[i];
        c  = ((c << 1) ^ (fb ? g : 16'h0)) & m;
      end
    end
    return c & m;
  endfunction

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // called at a falling edge; drives, waits one rising edge, compares at next falling edge
  task automatic apply(input logic v, input logic [7:0] b, input logic [1:0] s,
                       input logic l, input logic c, input string tag);
    byte_vld_i = v; byte_i = b; poly_sel_i = s; lsb_first_i = l; clear_i = c;
    if (c || s != exp_sel) exp_crc = 16'h0;
    else if (v)            exp_crc = ref_step(exp_crc, b, s, l);
    exp_sel = s;
    @(posedge clk);
    @(negedge clk);
    check(crc_o, exp_crc, tag);
  endtask

  task automatic run_string(input logic [1:0] s, input logic l,
                            input logic [15:0] known, input string tag);
    string str;
    str = "123456789";
    apply(1'b0, 8'h00, s, l, 1'b1, tag);
    for (int i = 0; i < str.len(); i++) begin
      byte_vld_i = 1'b1; byte_i = str[i]; poly_sel_i = s; lsb_first_i = l; clear_i = 1'b0;
      exp_crc = ref_step(exp_crc, str[i], s, l);
      exp_sel = s;
      @(posedge clk);
      @(negedge clk);
    end
    check(crc_o, known, tag);
  endtask

  initial begin
    #3000000;
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; byte_i = 8'hA5; byte_vld_i = 1'b1; poly_sel_i = 2'd2;
    lsb_first_i = 1'b0; clear_i = 1'b0;
    exp_crc = 16'h0; exp_sel = 2'd0;
    repeat (3) @(negedge clk);
    check(crc_o, 16'h0000, "R1 in reset");
    byte_vld_i = 1'b0; poly_sel_i = 2'd0;
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check(crc_o, 16'h0000, "R1 after release");

    // known residues
    run_string(2'd0, 1'b0, 16'h00F4, "R2 R6 8-bit check string");
    run_string(2'd3, 1'b0, 16'h00F4, "R5 reserved code as 8-bit");
    run_string(2'd1, 1'b0, 16'hFEE8, "R3 R6 8005 top-bit-first");
    run_string(2'd1, 1'b1, 16'hBB3D, "R3 R7 8005 low-bit-first");
    run_string(2'd2, 1'b0, 16'h31C3, "R4 R6 1021 top-bit-first");
    run_string(2'd2, 1'b1, 16'h2189, "R4 R7 1021 low-bit-first");

    // hold while idle
    apply(1'b1, 8'h3C, 2'd2, 1'b0, 1'b0, "R8 single byte");
    for (int i = 0; i < 3; i++) apply(1'b0, 8'hFF, 2'd2, 1'b0, 1'b0, "R9 idle hold");
    // clear discards the strobed byte
    apply(1'b1, 8'h77, 2'd2, 1'b0, 1'b1, "R10 clear with byte");
    // select change discards the strobed byte
    apply(1'b1, 8'h11, 2'd2, 1'b1, 1'b0, "R8 byte before change");
    apply(1'b1, 8'h22, 2'd1, 1'b1, 1'b0, "R11 select change with byte");
    apply(1'b1, 8'h22, 2'd3, 1'b1, 1'b0, "R11 change to reserved code");
    apply(1'b1, 8'h22, 2'd0, 1'b1, 1'b0, "R11 reserved to 0 clears");
    apply(1'b1, 8'hFF, 2'd0, 1'b1, 1'b0, "R7 R2 8-bit low-bit-first");
    check({8'h00, crc_o[15:8]}, 16'h0000, "R2 upper byte empty");

    // random streams
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] s;
      logic v, c, l;
      s = ((($urandom % 40) == 0)) ? 2'($urandom % 4) : exp_sel;
      v = ($urandom % 4) != 0;
      c = ($urandom % 60) == 0;
      l = ($urandom % 16 == 0) ? 1'($urandom) : lsb_first_i;
      apply(v, 8'($urandom), s, l, c, "R8 random stream");
      if (s == 2'd0 || s == 2'd3)
        check({8'h00, crc_o[15:8]}, 16'h0000, "R2 random upper byte");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule